// File: doc/BRIEF.md
# SMBus Slave Transfer Sequencer

This block is the slave side of a two-wire SMBus/I2C port. It runs on the system clock and samples the SDA and SCL bus lines through synchronizers. It spots START and STOP conditions and shifts in the seven-bit address and the direction bit. When the address matches its own address input, it passes every byte to software through a single interrupt flag. The flag comes with a four-bit status vector and three qualifier bits. Software answers each interrupt by clearing the flag. When it clears the flag it gives the acknowledge decision, or it first writes the next byte to transmit.

While the bus needs a decision from software, the block holds SCL low, so the master waits. SDA and SCL are open-drain: each output is an enable that pulls its line low. The block sets out what happens when software writes no byte after a transmit interrupt, and what happens when software writes a byte after the master has refused one.

Top module: `smb_slave_seq`

## Requirements
- R1: After a START (SDA falls while SCL is high), an address byte whose upper seven bits equal `own_addr` raises `si` after the eighth bit. It reports `status` = 4'b0010 and `ackrq` = 1, and `rx_data` holds the whole byte with the direction bit in bit 0 (1 = read).
- R2: Clearing the flag with `si_clr` while `ack_in` = 1 pulls SDA low for the acknowledge clock. With `ack_in` = 0 the block leaves SDA released for that clock. The block never pulls SDA while it holds SCL.
- R3: An address that does not match raises no interrupt and gets no acknowledge. The block ignores the rest of that transfer, including its STOP.
- R4: Once software refuses an address, no interrupt is raised for later data bytes or for the STOP until the next START. A START that follows with a matching address is served normally.
- R5: In write direction (bit 0 = 0), each data byte is received MSB first. It raises `si` with `status` = 4'b0000 and `ackrq` = 1, and `rx_data` holds the byte.
- R6: In read direction, a byte written through `wr_en`/`wr_data` before the address interrupt is cleared is sent MSB first, one bit per SCL low phase. SDA is released for the master's acknowledge clock.
- R7: Each sent byte raises `si` only after the master's acknowledge clock has ended. It reports `status` = 4'b0100 and `ackrq` = 0, with `ack_o` = 1 when the master pulled SDA low and 0 when the master left SDA high.
- R8: After a transmit interrupt with `ack_o` = 1, a byte written before `si_clr` is the next byte sent.
- R9: When a transmit interrupt with `ack_o` = 1 is cleared and no byte was written, SDA stays released. The next eight clocks are received as a data byte with `status` = 4'b0000.
- R10: A write while a transmit interrupt with `ack_o` = 0 is pending sets `arblost` = 1 with `status` = 4'b0100, and the byte is not queued.
- R11: A STOP while addressed, outside a byte being sent, raises `si` with `status` = 4'b0001 and `ackrq` = 0, and SCL is not held.
- R12: A STOP that arrives while a byte is being sent, before the master's acknowledge clock ends, raises `si` with `status` = 4'b0101.
- R13: After reset, `si`, `status`, `ackrq`, `arblost`, `ack_o`, `sda_oe` and `scl_oe` are all zero.
- R14: SCL is held low only while an address, receive or transmit interrupt is pending. It is released in the cycle after `si_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | DW-1 | Own seven-bit address |
| wr_en | input | 1 | Write pulse for the transmit byte |
| wr_data | input | DW | Byte to transmit |
| rx_data | output | DW | Last received address or data byte |
| si_clr | input | 1 | Clear the interrupt flag and apply the decision |
| ack_in | input | 1 | Decision applied with si_clr: 1 = ACK |
| si | output | 1 | Interrupt flag |
| status | output | 4 | Status vector {master, txmode, start, stop} |
| ackrq | output | 1 | Acknowledge decision requested |
| arblost | output | 1 | Error qualifier (write after NACK) |
| ack_o | output | 1 | Master acknowledge of the last sent byte |

## Verification
The bench uses the default byte width of eight bits, two synchronizer stages and own address 7'h5A. A bus half-period of eight clocks leaves room for the three-cycle edge-detect latency before each sample. Under these settings a bench master can stop mid-byte, pass a non-matching address, and stretch-wait through each software decision. The bench exercises write, read, refused-address and fallback transfers, and checks every interrupt against a queue of expected status items.

// File: rtl/smb_slave_seq.sv
module smb_slave_seq #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [DW-2:0] own_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rx_data,
  input  logic          si_clr,
  input  logic          ack_in,
  output logic          si,
  output logic [3:0]    status,
  output logic          ackrq,
  output logic          arblost,
  output logic          ack_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RX, S_ACKQ, S_ACKD, S_TX, S_MACK, S_TXQ} st_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[SYNC-1];
  wire sda_s = sda_sy[SYNC-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr, tx_sr, tx_buf;
  logic tx_full, is_addr, rw, ack_drv, addressed, ph;

  assign sda_oe = (st == S_ACKD && ack_drv) || (st == S_TX && !tx_sr[DW-1]);
  assign scl_oe = si && (st == S_ACKQ || st == S_TXQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx_sr     <= '1;
      tx_buf    <= '0;
      tx_full   <= 1'b0;
      is_addr   <= 1'b0;
      rw        <= 1'b0;
      ack_drv   <= 1'b0;
      addressed <= 1'b0;
      ph        <= 1'b0;
      rx_data   <= '0;
      si        <= 1'b0;
      status    <= 4'b0000;
      ackrq     <= 1'b0;
      arblost   <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      if (si_clr) si <= 1'b0;
      if (wr_en) begin
        if (st == S_TXQ && si && !ack_o) arblost <= 1'b1;
        else begin
          tx_buf  <= wr_data;
          tx_full <= 1'b1;
        end
      end
      if (bus_start) begin
        st      <= S_ADDR;
        cnt     <= '0;
        ack_drv <= 1'b0;
      end else if (bus_stop) begin
        if (addressed) begin
          si      <= 1'b1;
          status  <= (st == S_TX || st == S_MACK) ? 4'b0101 : 4'b0001;
          ackrq   <= 1'b0;
          arblost <= 1'b0;
        end
        st        <= S_IDLE;
        addressed <= 1'b0;
        ack_drv   <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt < CNT_FULL) begin
              sr  <= {sr[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              rx_data <= sr;
              cnt     <= '0;
              if (st == S_ADDR && sr[DW-1:1] != own_addr) begin
                st        <= S_IDLE;
                addressed <= 1'b0;
              end else begin
                si      <= 1'b1;
                status  <= (st == S_ADDR) ? 4'b0010 : 4'b0000;
                ackrq   <= 1'b1;
                arblost <= 1'b0;
                is_addr <= (st == S_ADDR);
                if (st == S_ADDR) rw <= sr[0];
                st      <= S_ACKQ;
              end
            end
          end
          S_ACKQ: begin
            if (si_clr) begin
              ackrq   <= 1'b0;
              ack_drv <= ack_in;
              ph      <= 1'b0;
              st      <= S_ACKD;
              if (is_addr) addressed <= ack_in;
            end
          end
          S_ACKD: begin
            if (scl_rise) ph <= 1'b1;
            else if (scl_fall && ph) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
              if (is_addr && !ack_drv) st <= S_IDLE;
              else if (is_addr && rw && tx_full) begin
                st      <= S_TX;
                tx_sr   <= tx_buf;
                tx_full <= 1'b0;
              end else st <= S_RX;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                st  <= S_MACK;
                ph  <= 1'b0;
                cnt <= '0;
              end else begin
                cnt   <= cnt + 1'b1;
                tx_sr <= {tx_sr[DW-2:0], 1'b1};
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              ph    <= 1'b1;
              ack_o <= ~sda_s;
            end else if (scl_fall && ph) begin
              si      <= 1'b1;
              status  <= 4'b0100;
              ackrq   <= 1'b0;
              arblost <= 1'b0;
              st      <= S_TXQ;
            end
          end
          S_TXQ: begin
            if (si_clr) begin
              cnt <= '0;
              if (!ack_o) st <= S_IDLE;
              else if (tx_full) begin
                st      <= S_TX;
                tx_sr   <= tx_buf;
                tx_full <= 1'b0;
              end else st <= S_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module smb_slave_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       si,
  input logic       si_clr,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       ackrq,
  input logic       arblost,
  input logic [3:0] status
);
  // R14
  hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (status == 4'b0010 || status == 4'b0000 || status == 4'b0100));
  // R14
  hold_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_clr && scl_oe) |=> !scl_oe);
  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !sda_oe);
  // R10
  err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arblost |-> status == 4'b0100);
  // R5
  ackrq_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackrq |-> (!status[2] && !status[0]));
  // R11
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && status[0]) |-> !scl_oe);
endmodule

bind smb_slave_seq smb_slave_seq_chk u_chk (.*);

// File: tb/test_smb_slave_seq.sv
module test_smb_slave_seq;
  localparam int CLK_P = 10;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_w, sda_w;
  logic wr_en = 1'b0, si_clr = 1'b0, ack_in = 1'b0;
  logic [7:0] wr_data = 8'h00, rx_data;
  logic si, ackrq, arblost, ack_o;
  logic [3:0] status;
  assign scl_w = scl_m & ~scl_oe;
  assign sda_w = sda_m & ~sda_oe;

  smb_slave_seq i_smb_slave_seq (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .wr_en(wr_en), .wr_data(wr_data), .rx_data(rx_data),
    .si_clr(si_clr), .ack_in(ack_in), .si(si), .status(status),
    .ackrq(ackrq), .arblost(arblost), .ack_o(ack_o));

  int total = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  typedef struct {
    logic [3:0] st; logic ackrq; logic chk_ack; logic ack;
    logic chk_data; logic [7:0] data; logic resp; logic do_wr;
    logic [7:0] wdata; logic err;
  } item_t;
  item_t q[$];
  string tq[$];

  task automatic push(input logic [3:0] st, input logic rq, input logic ca, input logic a,
                      input logic cd, input logic [7:0] d, input logic resp,
                      input logic dw, input logic [7:0] wd, input logic err, input string tag);
    item_t it;
    it.st = st; it.ackrq = rq; it.chk_ack = ca; it.ack = a; it.chk_data = cd;
    it.data = d; it.resp = resp; it.do_wr = dw; it.wdata = wd; it.err = err;
    q.push_back(it);
    tq.push_back(tag);
  endtask

  // monitor: software model and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && si) begin
        if (q.size() == 0) begin
          chk("R3 R4 unexpected interrupt", 1, 0);
          si_clr = 1'b1; @(negedge clk); si_clr = 1'b0;
        end else begin
          item_t it;
          string tg;
          it = q.pop_front();
          tg = tq.pop_front();
          chk({tg, " status"}, status, it.st);
          chk({tg, " ackrq"}, ackrq, it.ackrq);
          chk({"R14 hold ", tg}, scl_oe, !it.st[0]);
          if (it.chk_ack) chk({"R7 ack ", tg}, ack_o, it.ack);
          if (it.chk_data) chk({tg, " rx_data"}, rx_data, it.data);
          repeat (3) @(negedge clk);
          if (it.do_wr) begin
            wr_data = it.wdata; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
          end
          if (it.err) chk("R10 arblost", arblost, 1);
          ack_in = it.resp; si_clr = 1'b1;
          @(negedge clk);
          si_clr = 1'b0;
          chk("R14 release", scl_oe, 0);
        end
      end
    end
  end

  task automatic half(); repeat (H) @(negedge clk); endtask
  task automatic scl_up();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_w);
    half();
  endtask
  task automatic m_start(); sda_m = 1'b1; half(); scl_up(); sda_m = 1'b0; half(); scl_m = 1'b0; endtask
  task automatic m_stop(); @(negedge clk); sda_m = 1'b0; half(); scl_up(); sda_m = 1'b1; half(); endtask
  task automatic m_bit(input logic b, output logic r);
    @(negedge clk); sda_m = b; half(); scl_up(); r = sda_w; scl_m = 1'b0;
  endtask
  task automatic m_wbyte(input logic [7:0] d, output logic ab);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ab);
  endtask
  task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
    m_bit(!give_ack, r);
  endtask
  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    logic ab;
    logic [7:0] d;
    logic r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13 si", si, 0);
    chk("R13 status", status, 0);
    chk("R13 flags", {ackrq, arblost, ack_o}, 0);
    chk("R13 drive", {sda_oe, scl_oe}, 0);

    // write transfer
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b0}, 1, 0, 0, 0, "R1");
    push(4'b0000, 1, 0, 0, 1, 8'hA5, 1, 0, 0, 0, "R5");
    push(4'b0000, 1, 0, 0, 1, 8'h3C, 0, 0, 0, 0, "R5");
    push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    m_start();
    m_wbyte({OWN, 1'b0}, ab); chk("R2 address ack", ab, 0);
    m_wbyte(8'hA5, ab);       chk("R2 data ack", ab, 0);
    m_wbyte(8'h3C, ab);       chk("R2 data nack", ab, 1);
    m_stop(); drain();

    // non-matching address
    m_start();
    m_wbyte({7'h11, 1'b0}, ab); chk("R3 no ack", ab, 1);
    m_wbyte(8'h55, ab);         chk("R3 data ignored", ab, 1);
    m_stop(); drain();
    chk("R3 no interrupt", si, 0);

    // refused address, then served again
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b0}, 0, 0, 0, 0, "R4");
    m_start();
    m_wbyte({OWN, 1'b0}, ab); chk("R4 address nack", ab, 1);
    m_wbyte(8'h77, ab);       chk("R4 data ignored", ab, 1);
    m_stop(); drain();
    chk("R4 quiet", si, 0);
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b0}, 1, 0, 0, 0, "R4");
    push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    m_start();
    m_wbyte({OWN, 1'b0}, ab); chk("R4 served again", ab, 0);
    m_stop(); drain();

    // read transfer
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b1}, 1, 1, 8'hC3, 0, "R1");
    push(4'b0100, 0, 1, 1, 0, 0, 1, 1, 8'h5E, 0, "R7");
    push(4'b0100, 0, 1, 0, 0, 0, 0, 1, 8'h99, 1, "R10");
    push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    m_start();
    m_wbyte({OWN, 1'b1}, ab); chk("R2 read address ack", ab, 0);
    m_rbyte(d, 1'b1); chk("R6 first byte", d, 8'hC3);
    m_rbyte(d, 1'b0); chk("R8 next byte", d, 8'h5E);
    m_stop(); drain();

    // fallback to receive
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b1}, 1, 1, 8'h81, 0, "R1");
    push(4'b0100, 0, 1, 1, 0, 0, 1, 0, 0, 0, "R9");
    push(4'b0000, 1, 0, 0, 1, 8'h3C, 1, 0, 0, 0, "R9");
    push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    m_start();
    m_wbyte({OWN, 1'b1}, ab);
    m_rbyte(d, 1'b1); chk("R6 byte", d, 8'h81);
    m_wbyte(8'h3C, ab); chk("R9 received ack", ab, 0);
    m_stop(); drain();

    // stop in the middle of a sent byte
    push(4'b0010, 1, 0, 0, 1, {OWN, 1'b1}, 1, 1, 8'hFF, 0, "R1");
    push(4'b0101, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    m_start();
    m_wbyte({OWN, 1'b1}, ab);
    for (int i = 0; i < 3; i++) m_bit(1'b1, r);
    m_stop(); drain();

    chk("R3 R4 all expected interrupts seen", q.size(), 0);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 0, 1);
    report();
    $finish;
  end
endmodule